// File: doc/BRIEF.md
# Fine-Scroll Video Address Generator

This block produces the word addresses that a bitplane display controller uses to fetch screen data from memory, with hardware support for pixel-accurate horizontal scrolling and for displays narrower than the image held in memory. A host writes a screen base, a 4-bit pixel offset, an 8-bit line skip in words and, when it needs to, the running address counter itself. A timing generator supplies line-start, line-end and vertical-blank strobes.

For each line the block issues one fetch request per fetch unit, one per clock, stepping through memory. It also presents the pixel offset that the downstream serializer applies to the first word of the line. When a nonzero offset is loaded through the main scroll register, the line needs one more unit of data, so the block fetches one extra unit. A second scroll register loads the same offset without that extra unit. At each line end the skip is added to the counter, so a window can be opened onto a wider virtual screen. At vertical blank the counter is reloaded from the base.

Top module: `fscroll_addr_gen`

## Requirements
- R1: A synchronous active-high reset clears the base, the line skip, the pixel offset and the address counter. While reset is held and in the cycle after it, `fetch_req` is 0, `fetch_addr` is 0 and `pix_shift` is 0.
- R2: Every address is word aligned. Bit 0 of the base and of the counter is forced to 0 whatever the host writes, so `fetch_addr[0]` is always 0.
- R3: A write to the base (`host_sel`=0) does not change the addresses fetched until the next `vblank` strobe. That strobe copies the base into the counter.
- R4: A write to the counter (`host_sel`=4) takes effect at once, also in the middle of a frame. The next fetch uses the written value with bit 0 cleared.
- R5: `res_mode` sets the fetch unit and the line length. Mode 0 uses 4 words (8 bytes) per unit and 20 units per line. Mode 1 uses 2 words (4 bytes) per unit and 40 units. Modes 2 and 3 use 1 word (2 bytes) per unit and 40 units. Within a line, consecutive addresses differ by the unit size in bytes.
- R6: On each `line_end` strobe the counter advances by twice the line skip (`host_sel`=1, value in words). A skip of 0 makes lines contiguous.
- R7: When the offset was last written through the main scroll register (`host_sel`=2) and is nonzero, each line has one extra unit (21 or 41 requests). An offset of 0 adds nothing.
- R8: The alternate scroll register (`host_sel`=3) sets the same shared offset but never adds the extra unit. Whichever scroll register was written last decides both the offset and whether the extra unit is fetched.
- R9: `pix_shift` and the unit settings take a new value only at a `line_start` strobe. A scroll write during a line is used from the next line.
- R10: After a `line_start` strobe, `fetch_req` rises one cycle later and stays high for one unbroken run of the line's unit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 3 | Register select: 0 base, 1 line skip, 2 scroll, 3 alternate scroll, 4 counter |
| host_wdata | input | 24 | Write data, right aligned |
| res_mode | input | 2 | Resolution: 0 four-plane, 1 two-plane, 2/3 monochrome |
| line_start | input | 1 | Start of a displayed line |
| line_end | input | 1 | End of a displayed line |
| vblank | input | 1 | Vertical blank strobe |
| fetch_req | output | 1 | Fetch one unit at `fetch_addr` |
| fetch_addr | output | 24 | Byte address of the unit, word aligned |
| pix_shift | output | 4 | Pixel offset for the serializer |

## Verification
The hardest case to reach is a change in the middle of a frame that must stay hidden until a later strobe. Examples are a base write before the vblank strobe, or a scroll write while a line is being fetched. These pass the host interface cleanly, yet they must not show on the fetch outputs. The bench writes the register between strobes, runs a whole line, and compares the first address and `pix_shift` with the old values. It then sends the strobe and looks for the new values. The switch between the two scroll registers is also covered: the same offset is written first through one register and then the other, and the request count of each line is compared.

// File: rtl/fsa_pkg.sv
package fsa_pkg;
  typedef enum logic [2:0] {
    SEL_BASE     = 3'd0,
    SEL_LSKIP    = 3'd1,
    SEL_SCROLL   = 3'd2,
    SEL_SCRL_ALT = 3'd3,
    SEL_COUNTER  = 3'd4
  } host_sel_e;

  // bytes covered by one fetch unit for a resolution code
  function automatic logic [3:0] unit_bytes(input logic [1:0] mode);
    case (mode)
      2'd0:    unit_bytes = 4'd8;
      2'd1:    unit_bytes = 4'd4;
      default: unit_bytes = 4'd2;
    endcase
  endfunction
endpackage

// File: rtl/fsa_host_regs.sv
module fsa_host_regs
  import fsa_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LW_W   = 8,
  parameter int SH_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [2:0]        host_sel,
  input  logic [ADDR_W-1:0] host_wdata,
  output logic [ADDR_W-1:0] base_q,
  output logic [LW_W-1:0]   lskip_q,
  output logic [SH_W-1:0]   shift_q,
  output logic              extra_en_q,
  output logic              ctr_ld,
  output logic [ADDR_W-1:0] ctr_val
);
  logic [ADDR_W-1:0] aligned;
  assign aligned = {host_wdata[ADDR_W-1:1], 1'b0};
  assign ctr_ld  = host_we && (host_sel == SEL_COUNTER);
  assign ctr_val = aligned;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q     <= '0;
      lskip_q    <= '0;
      shift_q    <= '0;
      extra_en_q <= 1'b0;
    end else if (host_we) begin
      case (host_sel)
        SEL_BASE:     base_q <= aligned;
        SEL_LSKIP:    lskip_q <= host_wdata[LW_W-1:0];
        SEL_SCROLL: begin
          shift_q    <= host_wdata[SH_W-1:0];
          extra_en_q <= 1'b1;
        end
        SEL_SCRL_ALT: begin
          shift_q    <= host_wdata[SH_W-1:0];
          extra_en_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fsa_fetch_seq.sv
module fsa_fetch_seq
  import fsa_pkg::*;
#(
  parameter int UNITS_LO = 20,
  parameter int UNITS_HI = 40,
  parameter int SH_W     = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            line_start,
  input  logic [1:0]      mode,
  input  logic [SH_W-1:0] shift_in,
  input  logic            extra_en,
  output logic            active,
  output logic [3:0]      step_bytes,
  output logic [SH_W-1:0] pix_shift
);
  localparam int CNT_W = $clog2(UNITS_HI + 2);

  logic [CNT_W-1:0] left_q;
  logic [CNT_W-1:0] base_units;
  logic             add_unit;

  assign base_units = (mode == 2'd0) ? CNT_W'(UNITS_LO) : CNT_W'(UNITS_HI);
  assign add_unit   = extra_en && (shift_in != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      left_q     <= '0;
      step_bytes <= 4'd8;
      pix_shift  <= '0;
    end else if (line_start) begin
      active     <= 1'b1;
      left_q     <= base_units + CNT_W'(add_unit);
      step_bytes <= unit_bytes(mode);
      pix_shift  <= shift_in;
    end else if (active) begin
      left_q <= left_q - 1'b1;
      if (left_q == CNT_W'(1)) active <= 1'b0;
    end
  end
endmodule

// File: rtl/fsa_addr_ctr.sv
module fsa_addr_ctr #(
  parameter int ADDR_W = 24,
  parameter int LW_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_ld,
  input  logic [ADDR_W-1:0] host_val,
  input  logic              frame_ld,
  input  logic [ADDR_W-1:0] base_val,
  input  logic              advance,
  input  logic [3:0]        step_bytes,
  input  logic              line_end,
  input  logic [LW_W-1:0]   lskip,
  output logic [ADDR_W-1:0] ctr_q
);
  logic [ADDR_W-1:0] unit_add;
  logic [ADDR_W-1:0] skip_add;

  assign unit_add = advance  ? ADDR_W'(step_bytes) : '0;
  assign skip_add = line_end ? ADDR_W'({lskip, 1'b0}) : '0;

  always_ff @(posedge clk) begin
    if (rst)           ctr_q <= '0;
    else if (host_ld)  ctr_q <= {host_val[ADDR_W-1:1], 1'b0};
    else if (frame_ld) ctr_q <= {base_val[ADDR_W-1:1], 1'b0};
    else               ctr_q <= ctr_q + unit_add + skip_add;
  end
endmodule

// File: rtl/fscroll_addr_gen.sv
module fscroll_addr_gen #(
  parameter int ADDR_W   = 24,
  parameter int LW_W     = 8,
  parameter int SH_W     = 4,
  parameter int UNITS_LO = 20,
  parameter int UNITS_HI = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [2:0]        host_sel,
  input  logic [ADDR_W-1:0] host_wdata,
  input  logic [1:0]        res_mode,
  input  logic              line_start,
  input  logic              line_end,
  input  logic              vblank,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [SH_W-1:0]   pix_shift
);
  logic [ADDR_W-1:0] base_q, ctr_val, ctr_q;
  logic [LW_W-1:0]   lskip_q;
  logic [SH_W-1:0]   shift_q;
  logic              extra_en_q, ctr_host_ld, seq_active;
  logic [3:0]        step_bytes;

  fsa_host_regs #(.ADDR_W(ADDR_W), .LW_W(LW_W), .SH_W(SH_W)) u_regs (
    .clk, .rst, .host_we, .host_sel, .host_wdata,
    .base_q, .lskip_q, .shift_q, .extra_en_q,
    .ctr_ld(ctr_host_ld), .ctr_val
  );

  fsa_fetch_seq #(.UNITS_LO(UNITS_LO), .UNITS_HI(UNITS_HI), .SH_W(SH_W)) u_seq (
    .clk, .rst, .line_start, .mode(res_mode), .shift_in(shift_q),
    .extra_en(extra_en_q), .active(seq_active), .step_bytes, .pix_shift
  );

  fsa_addr_ctr #(.ADDR_W(ADDR_W), .LW_W(LW_W)) u_ctr (
    .clk, .rst, .host_ld(ctr_host_ld), .host_val(ctr_val),
    .frame_ld(vblank), .base_val(base_q), .advance(seq_active),
    .step_bytes, .line_end, .lskip(lskip_q), .ctr_q
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_req  <= 1'b0;
      fetch_addr <= '0;
    end else begin
      fetch_req  <= seq_active;
      fetch_addr <= seq_active ? ctr_q : fetch_addr;
    end
  end
endmodule

// File: rtl/fsa_checker.sv
module fsa_checker #(
  parameter int ADDR_W = 24,
  parameter int SH_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_req,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic [SH_W-1:0]   pix_shift,
  input logic              line_start,
  input logic              line_end,
  input logic              vblank,
  input logic              ctr_load,
  input logic [ADDR_W-1:0] host_wdata,
  input logic [ADDR_W-1:0] ctr_q,
  input logic [ADDR_W-1:0] base_q,
  input logic [3:0]        step_bytes
);
  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (!fetch_req && fetch_addr == '0 && pix_shift == '0));

  p_align_r2: assert property (@(posedge clk) disable iff (rst)
    fetch_req |-> (fetch_addr[0] == 1'b0));

  p_vbl_load_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(vblank) && !$past(ctr_load)) |-> (ctr_q == $past(base_q)));

  p_ctr_write_r4: assert property (@(posedge clk) disable iff (rst)
    $past(ctr_load) |-> (ctr_q == {$past(host_wdata[ADDR_W-1:1]), 1'b0}));

  p_unit_step_r5: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && $past(fetch_req) && !$past(ctr_load, 2) && !$past(vblank, 2)
     && !$past(line_end, 2))
    |-> (fetch_addr == $past(fetch_addr) + ADDR_W'(step_bytes)));

  p_shift_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(line_start) |-> $stable(pix_shift));
endmodule

bind fscroll_addr_gen fsa_checker #(.ADDR_W(ADDR_W), .SH_W(SH_W)) u_chk (
  .clk, .rst, .fetch_req, .fetch_addr, .pix_shift, .line_start, .line_end,
  .vblank, .ctr_load(ctr_host_ld), .host_wdata, .ctr_q, .base_q, .step_bytes
);

// File: tb/sim_fscroll_addr_gen.sv
`timescale 1ns/1ps
module sim_fscroll_addr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [2:0]  host_sel = '0;
  logic [23:0] host_wdata = '0;
  logic [1:0]  res_mode = '0;
  logic        line_start = 1'b0, line_end = 1'b0, vblank = 1'b0;
  logic        fetch_req;
  logic [23:0] fetch_addr;
  logic [3:0]  pix_shift;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fscroll_addr_gen u0 (.*);

  // row: mode[38:37] skip[36:29] scroll[28:25] alt[24] base[23:0]
  localparam logic [38:0] VEC [5] = '{
    {2'd0, 8'h00, 4'h0, 1'b0, 24'h010000},
    {2'd1, 8'h05, 4'h3, 1'b0, 24'h020100},
    {2'd2, 8'hFF, 4'h7, 1'b1, 24'h0300F0},
    {2'd0, 8'h10, 4'hF, 1'b0, 24'hFFFF00},
    {2'd3, 8'h00, 4'h0, 1'b0, 24'h000002}
  };

  int m_cnt; logic [23:0] m_first, m_last; int m_badstep; bit m_gap;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [23:0] d);
    @(negedge clk); host_we = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic strobe_vbl();
    @(negedge clk); vblank = 1'b1; @(negedge clk); vblank = 1'b0;
  endtask
  task automatic strobe_end();
    @(negedge clk); line_end = 1'b1; @(negedge clk); line_end = 1'b0;
  endtask

  // pulses line_start and watches the following 60 cycles
  task automatic run_line(input int step);
    bit seen_end;
    @(negedge clk); line_start = 1'b1; @(negedge clk); line_start = 1'b0;
    m_cnt = 0; m_badstep = 0; m_gap = 1'b0; seen_end = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (fetch_req) begin
        if (seen_end) m_gap = 1'b1;
        if (m_cnt == 0) begin
          m_first = fetch_addr;
          if (i != 0) m_gap = 1'b1;
        end else if (fetch_addr != m_last + 24'(step)) m_badstep++;
        m_last = fetch_addr;
        m_cnt++;
      end else if (m_cnt > 0) seen_end = 1'b1;
    end
  endtask

  function automatic int ubytes(input logic [1:0] m);
    return (m == 2'd0) ? 8 : (m == 2'd1) ? 4 : 2;
  endfunction
  function automatic int units(input logic [1:0] m);
    return (m == 2'd0) ? 20 : 40;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!fetch_req && fetch_addr == 0 && pix_shift == 0, "R1", "outputs in reset",
          {fetch_req, fetch_addr, pix_shift}, 0);
    @(negedge clk); rst = 1'b0;
    res_mode = 2'd0;
    run_line(8);
    check(m_first == 24'h0 && m_cnt == 20, "R1", "first line after reset",
          m_first, 0);

    foreach (VEC[k]) begin
      logic [1:0] md; logic [7:0] sk; logic [3:0] sc; bit alt; logic [23:0] bs;
      int n; logic [23:0] nxt;
      {md, sk, sc, alt, bs} = VEC[k];
      res_mode = md;
      wr(3'd0, bs);
      wr(3'd1, 24'(sk));
      wr(alt ? 3'd3 : 3'd2, 24'(sc));
      strobe_vbl();
      run_line(ubytes(md));
      n = units(md) + ((!alt && sc != 0) ? 1 : 0);
      check(m_cnt == n, alt ? "R8" : "R7", "units per line", m_cnt, n);
      check(m_first == bs, "R3", "line start after vblank", m_first, bs);
      check(m_badstep == 0, "R5", "unit step", m_badstep, 0);
      check(!m_gap, "R10", "contiguous requests", m_gap, 0);
      check(pix_shift == sc, "R9", "pixel offset", pix_shift, sc);
      nxt = bs + 24'(n * ubytes(md)) + 24'({sk, 1'b0});
      strobe_end();
      run_line(ubytes(md));
      check(m_first == nxt, "R6", "next line start", m_first, nxt);
    end

    // R2: odd base is forced even
    res_mode = 2'd2;
    wr(3'd1, 24'h0);
    wr(3'd2, 24'h0);
    wr(3'd0, 24'h123457);
    strobe_vbl();
    run_line(2);
    check(m_first == 24'h123456, "R2", "aligned base", m_first, 24'h123456);

    // R3: base write mid-frame has no effect before vblank
    wr(3'd0, 24'h400000);
    strobe_end();
    run_line(2);
    check(m_first == 24'h123456 + 24'd80, "R3", "base held until vblank",
          m_first, 24'h123456 + 24'd80);
    strobe_vbl();
    run_line(2);
    check(m_first == 24'h400000, "R3", "base after vblank", m_first, 24'h400000);

    // R4: counter write is immediate and aligned
    wr(3'd4, 24'h0ABCD1);
    run_line(2);
    check(m_first == 24'h0ABCD0, "R4", "counter write", m_first, 24'h0ABCD0);

    // R9: scroll write during a line is deferred to the next line
    res_mode = 2'd0;
    wr(3'd2, 24'h0);
    @(negedge clk); line_start = 1'b1; @(negedge clk); line_start = 1'b0;
    repeat (3) @(negedge clk);
    host_we = 1'b1; host_sel = 3'd2; host_wdata = 24'h9;
    @(negedge clk); host_we = 1'b0;
    repeat (2) @(negedge clk);
    check(pix_shift == 4'h0, "R9", "offset held mid-line", pix_shift, 0);
    repeat (30) @(negedge clk);
    run_line(8);
    check(pix_shift == 4'h9, "R9", "offset at next line", pix_shift, 4'h9);
    check(m_cnt == 21, "R7", "extra unit for nonzero offset", m_cnt, 21);

    // R8: last scroll register written decides the extra unit
    wr(3'd3, 24'h9);
    run_line(8);
    check(m_cnt == 20 && pix_shift == 4'h9, "R8", "alternate drops extra unit",
          m_cnt, 20);
    wr(3'd2, 24'h9);
    run_line(8);
    check(m_cnt == 21, "R8", "main restores extra unit", m_cnt, 21);

    // R1: reset mid-stream clears everything
    @(negedge clk); rst = 1'b1; @(negedge clk); @(negedge clk); rst = 1'b0;
    check(!fetch_req && fetch_addr == 0 && pix_shift == 0, "R1", "after reset",
          {fetch_req, fetch_addr, pix_shift}, 0);
    run_line(8);
    check(m_first == 0 && m_cnt == 20 && pix_shift == 0, "R1", "cleared registers",
          m_cnt, 20);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule